// File: doc/BRIEF.md
# Multiple-Register Block Transfer Sequencer

This controller carries out one block load or block store of an arbitrary subset of sixteen general registers. A single start pulse supplies a 16-bit selection mask, a base address, a direction (load or store) and a writeback flag. The sequencer then walks the mask from the lowest selected register to the highest. For each selected register it issues one full-word memory request, at consecutive word addresses that begin at the base itself.

Each request is held on the memory side until the memory answers with ready. On a load, the accepted cycle also produces a register-file write of the returned word. On a store, the sequencer drives the register-file read select, and the read word is forwarded as store data. When the last selected register has been accepted, the sequencer raises done for one cycle. In that cycle it presents the updated base (base plus four bytes per transferred register) and a base-write strobe when writeback was requested. The register file and the memory sit outside the block.

Top module: `blockxfer_seq`

## Requirements
- R1: After reset the sequencer is idle: busy, done, memValid and rfWrEn are all low.
- R2: One memory request is issued per set mask bit, in ascending register index order, lowest index first; memIdx names the register being transferred.
- R3: The first request uses baseAddr itself and each later request adds 4 to the previous address (modulo 2^32).
- R4: While memValid is high and memReady is low, memAddr, memIdx and memWrite hold their values and the request stays up.
- R5: On a load (isLoad=1), memWrite is 0, and in the cycle a request is accepted rfWrEn is 1 with rfWrIdx equal to memIdx and rfWrData equal to memRdata; rfWrEn is 0 in every other cycle.
- R6: On a store (isLoad=0), memWrite is 1 during each request, rfRdIdx equals memIdx, and memWdata equals rfRdData.
- R7: done is high for exactly one cycle: the cycle after the final request is accepted. busy is high from the cycle after start until that done cycle inclusive.
- R8: During done, newBase equals baseAddr + 4 × (number of set mask bits), and baseWrEn is high exactly when wbEnable was set at start.
- R9: An all-zero mask raises done in the first cycle after start without any memory request, and newBase equals baseAddr.
- R10: A start pulse while busy (including the done cycle) is ignored: the transfer in progress and its captured mask, base and direction are unaffected, and no new transfer begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Starts a transfer when idle |
| regMask | input | 16 | Registers to transfer, bit i selects register i |
| baseAddr | input | 32 | Byte address of the first word |
| isLoad | input | 1 | 1 = load into registers, 0 = store from registers |
| wbEnable | input | 1 | Request base writeback at the end |
| memValid | output | 1 | Memory request present |
| memReady | input | 1 | Memory accepts the current request |
| memWrite | output | 1 | Request is a store |
| memAddr | output | 32 | Word address of the current request |
| memIdx | output | 4 | Register index of the current request |
| memRdata | input | 32 | Word returned by memory in the accepting cycle |
| memWdata | output | 32 | Store data |
| rfWrEn | output | 1 | Register-file write strobe (loads) |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| rfRdIdx | output | 4 | Register-file read select (stores) |
| rfRdData | input | 32 | Register-file read data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| newBase | output | 32 | Updated base, valid with done |
| baseWrEn | output | 1 | Base writeback strobe, with done |

## Verification
The hardest case is a start pulse that arrives in the middle of a transfer while memory is stalling, or during the single done cycle. Only this stimulus would expose a sequencer that recaptures its inputs. The bench reaches it deliberately: on chosen runs it raises startPulse with a full mask and a different base in the first stalled request cycle and again in the done cycle. It then checks that the remaining addresses, indices and the final base still follow the original request. Each mask is also driven against pseudo-random ready stalls, so the same request must be held stable across waits of up to three cycles.

// File: rtl/blockxfer_pkg.sv
package blockxfer_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // capture start inputs
    logic advance;  // retire current register, step address
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic inEmpty;      // incoming mask has no bits set
    logic lastPending;  // at most one bit left in the working mask
  } seqStatus_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_XFER = 2'd1,
    SEQ_FIN  = 2'd2
  } seqState_t;

endpackage

// File: rtl/blockxfer_ctrl.sv
module blockxfer_ctrl
  import blockxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       memReady,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       memValid,
  output logic       busy,
  output logic       done
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      SEQ_IDLE: begin
        if (startPulse) begin
          strobe.load = 1'b1;
          stateD      = status.inEmpty ? SEQ_FIN : SEQ_XFER;
        end
      end
      SEQ_XFER: begin
        if (memReady) begin
          strobe.advance = 1'b1;
          if (status.lastPending) stateD = SEQ_FIN;
        end
      end
      SEQ_FIN:  stateD = SEQ_IDLE;
      default:  stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEQ_IDLE;
    else       stateQ <= stateD;
  end

  assign memValid = (stateQ == SEQ_XFER);
  assign busy     = (stateQ != SEQ_IDLE);
  assign done     = (stateQ == SEQ_FIN);

endmodule

// File: rtl/blockxfer_dp.sv
module blockxfer_dp
  import blockxfer_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [NUM_REGS-1:0] regMask,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic                isLoad,
  input  logic                wbEnable,
  output seqStatus_t          status,
  output logic [IDX_W-1:0]    curIdx,
  output logic [ADDR_W-1:0]   curAddr,
  output logic                loadQ,
  output logic                wbQ
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [NUM_REGS-1:0] pendQ;
  logic [NUM_REGS-1:0] pendLowCleared;

  // lowest set bit wins: scan downward so the last hit is the lowest
  always_comb begin
    curIdx = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (pendQ[i]) curIdx = IDX_W'(i);
    end
  end

  assign pendLowCleared     = pendQ & (pendQ - 1'b1);
  assign status.lastPending = (pendLowCleared == '0);
  assign status.inEmpty     = (regMask == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      curAddr <= '0;
      loadQ   <= 1'b0;
      wbQ     <= 1'b0;
    end else if (strobe.load) begin
      pendQ   <= regMask;
      curAddr <= baseAddr;
      loadQ   <= isLoad;
      wbQ     <= wbEnable;
    end else if (strobe.advance) begin
      pendQ   <= pendLowCleared;
      curAddr <= curAddr + STEP;
    end
  end

endmodule

// File: rtl/blockxfer_seq.sv
module blockxfer_seq
  import blockxfer_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [NUM_REGS-1:0] regMask,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic                isLoad,
  input  logic                wbEnable,
  output logic                memValid,
  input  logic                memReady,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [IDX_W-1:0]    memIdx,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [DATA_W-1:0]   memWdata,
  output logic                rfWrEn,
  output logic [IDX_W-1:0]    rfWrIdx,
  output logic [DATA_W-1:0]   rfWrData,
  output logic [IDX_W-1:0]    rfRdIdx,
  input  logic [DATA_W-1:0]   rfRdData,
  output logic                busy,
  output logic                done,
  output logic [ADDR_W-1:0]   newBase,
  output logic                baseWrEn
);

  seqStrobe_t       strobe;
  seqStatus_t       status;
  logic [IDX_W-1:0] curIdx;
  logic [ADDR_W-1:0] curAddr;
  logic             loadQ;
  logic             wbQ;

  blockxfer_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .memReady   (memReady),
    .status     (status),
    .strobe     (strobe),
    .memValid   (memValid),
    .busy       (busy),
    .done       (done)
  );

  blockxfer_dp #(
    .NUM_REGS   (NUM_REGS),
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regMask  (regMask),
    .baseAddr (baseAddr),
    .isLoad   (isLoad),
    .wbEnable (wbEnable),
    .status   (status),
    .curIdx   (curIdx),
    .curAddr  (curAddr),
    .loadQ    (loadQ),
    .wbQ      (wbQ)
  );

  assign memAddr  = curAddr;
  assign memIdx   = curIdx;
  assign memWrite = memValid & ~loadQ;
  assign memWdata = rfRdData;
  assign rfRdIdx  = curIdx;
  assign rfWrEn   = memValid & memReady & loadQ;
  assign rfWrIdx  = curIdx;
  assign rfWrData = memRdata;
  assign newBase  = curAddr;
  assign baseWrEn = done & wbQ;

endmodule

// File: rtl/blockxfer_seq_chk.sv
module blockxfer_seq_chk #(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              memValid,
  input logic              memReady,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [IDX_W-1:0]  memIdx,
  input logic              rfWrEn,
  input logic              busy,
  input logic              done
);

  // R1: nothing happens on the ports while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memValid && !rfWrEn && !done));

  // R2: indices strictly ascend within a transfer
  p_idx_ascend_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (!memValid || memIdx > $past(memIdx)));

  // R3: each accepted request is followed by one a word further on
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=>
      (!memValid || memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES)));

  // R4: a stalled request is held
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=>
      (memValid && $stable(memAddr) && $stable(memIdx) && $stable(memWrite)));

  // R5: register writes only on accepted load requests
  p_wr_on_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (memValid && memReady && !memWrite));

  // R6: store requests never write the register file
  p_store_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (memValid && !rfWrEn));

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a start in the done cycle does not relaunch
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && startPulse) |=> !busy);

endmodule

bind blockxfer_seq blockxfer_seq_chk #(
  .NUM_REGS   (NUM_REGS),
  .ADDR_W     (ADDR_W),
  .WORD_BYTES (WORD_BYTES)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .memValid   (memValid),
  .memReady   (memReady),
  .memWrite   (memWrite),
  .memAddr    (memAddr),
  .memIdx     (memIdx),
  .rfWrEn     (rfWrEn),
  .busy       (busy),
  .done       (done)
);

// File: tb/blockxfer_seq_tb_top.sv
module blockxfer_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [15:0] regMask = '0;
  logic [31:0] baseAddr = '0;
  logic        isLoad = 1'b0;
  logic        wbEnable = 1'b0;
  logic        memValid;
  logic        memReady = 1'b0;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [3:0]  memIdx;
  logic [31:0] memRdata;
  logic [31:0] memWdata;
  logic        rfWrEn;
  logic [3:0]  rfWrIdx;
  logic [31:0] rfWrData;
  logic [3:0]  rfRdIdx;
  logic [31:0] rfRdData;
  logic        busy;
  logic        done;
  logic [31:0] newBase;
  logic        baseWrEn;

  int tests = 0;
  int fails = 0;
  logic [15:0] stallLfsr = 16'hACE1;

  always #4 clk = ~clk;

  // memory and register file models
  assign memRdata = memAddr ^ 32'h5A5A_0000;
  assign rfRdData = 32'hC0DE_0000 | {28'd0, rfRdIdx};

  blockxfer_seq dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .regMask(regMask),
    .baseAddr(baseAddr), .isLoad(isLoad), .wbEnable(wbEnable),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memIdx(memIdx), .memRdata(memRdata),
    .memWdata(memWdata), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .busy(busy), .done(done), .newBase(newBase), .baseWrEn(baseWrEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nextLfsr(input logic [15:0] v);
    return v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
  endfunction

  // one block transfer, checked cycle by cycle; poke = start pulses while busy
  task automatic runXfer(input logic [15:0] mask, input logic [31:0] base,
                         input logic ld, input logic wb, input bit poke);
    logic [15:0] rem = mask;
    logic [31:0] addr = base;
    int          nSet = 0;
    int          stallRun = 0;
    bit          poked = 0;
    int          expIdx;
    for (int i = 0; i < 16; i++) if (mask[i]) nSet++;

    @(negedge clk);
    startPulse = 1'b1; regMask = mask; baseAddr = base; isLoad = ld; wbEnable = wb;
    @(negedge clk);
    startPulse = 1'b0; regMask = '0; baseAddr = 32'h0BAD_0000; isLoad = ~ld; wbEnable = ~wb;

    while (rem != 16'd0) begin
      expIdx = 0;
      for (int i = 15; i >= 0; i--) if (rem[i]) expIdx = i;
      stallLfsr = nextLfsr(stallLfsr);
      memReady = (stallLfsr[1:0] == 2'b00 && stallRun < 3) ? 1'b0 : 1'b1;
      if (poke && !poked) begin
        memReady = 1'b0;
        startPulse = 1'b1; regMask = 16'hFFFF; baseAddr = 32'h7777_0000;
        poked = 1;
      end
      stallRun = memReady ? 0 : stallRun + 1;
      #1;
      chk("R2 memValid", {31'd0, memValid}, 32'd1);
      chk("R2 memIdx", {28'd0, memIdx}, expIdx);
      chk("R3 memAddr", memAddr, addr);
      chk("R5/R6 memWrite", {31'd0, memWrite}, {31'd0, ~ld});
      chk("R7 busy", {31'd0, busy}, 32'd1);
      if (ld) begin
        chk("R5 rfWrEn", {31'd0, rfWrEn}, {31'd0, memReady});
        chk("R5 rfWrIdx", {28'd0, rfWrIdx}, expIdx);
        chk("R5 rfWrData", rfWrData, addr ^ 32'h5A5A_0000);
      end else begin
        chk("R6 rfWrEn", {31'd0, rfWrEn}, 32'd0);
        chk("R6 rfRdIdx", {28'd0, rfRdIdx}, expIdx);
        chk("R6 memWdata", memWdata, 32'hC0DE_0000 | expIdx);
      end
      if (memReady) begin
        rem[expIdx] = 1'b0;
        addr = addr + 32'd4;
      end
      @(negedge clk);
      startPulse = 1'b0;
    end
    memReady = 1'b0;
    if (poke) begin
      startPulse = 1'b1; regMask = 16'hFFFF; baseAddr = 32'h7777_0000;
    end
    #1;
    // done cycle (R9 when mask is empty)
    chk(mask == 0 ? "R9 done" : "R7 done", {31'd0, done}, 32'd1);
    chk("R7 busy at done", {31'd0, busy}, 32'd1);
    chk(mask == 0 ? "R9 no request" : "R7 no request", {31'd0, memValid}, 32'd0);
    chk(mask == 0 ? "R9 newBase" : "R8 newBase", newBase, base + 32'(4 * nSet));
    chk("R8 baseWrEn", {31'd0, baseWrEn}, {31'd0, wb});
    @(negedge clk);
    startPulse = 1'b0;
    #1;
    chk(poke ? "R10 idle after done" : "R7 idle after done", {31'd0, busy}, 32'd0);
    chk("R7 done single", {31'd0, done}, 32'd0);
    chk("R1 no request idle", {31'd0, memValid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] mLfsr = 16'h1D2B;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 memValid", {31'd0, memValid}, 32'd0);
    chk("R1 rfWrEn", {31'd0, rfWrEn}, 32'd0);
    rstN = 1'b1;

    // R9: empty masks, with and without writeback
    runXfer(16'h0000, 32'h0000_1000, 1'b1, 1'b1, 0);
    runXfer(16'h0000, 32'h0000_2000, 1'b0, 1'b0, 0);
    // four registers from 1000 end at 1016
    runXfer(16'h00C3, 32'd1000, 1'b1, 1'b1, 0);
    // full and extreme single-bit masks
    runXfer(16'hFFFF, 32'h0000_4000, 1'b0, 1'b1, 0);
    runXfer(16'hFFFF, 32'h0000_5000, 1'b1, 1'b0, 0);
    // address wrap past the top of the space (R3)
    runXfer(16'h8421, 32'hFFFF_FFF8, 1'b1, 1'b1, 0);
    // every single-register mask, both directions
    for (int b = 0; b < 16; b++) begin
      runXfer(16'(1 << b), 32'h0001_0000 + 32'(b * 64), b[0], b[1], 0);
    end
    // R10: start pulses during a stalled request and during done
    runXfer(16'h0A50, 32'h0002_0000, 1'b1, 1'b1, 1);
    runXfer(16'h0001, 32'h0003_0000, 1'b0, 1'b1, 1);
    runXfer(16'h0000, 32'h0004_0000, 1'b0, 1'b1, 1);
    // pseudo-random mask sweep
    for (int n = 0; n < 160; n++) begin
      mLfsr = nextLfsr(mLfsr);
      runXfer(mLfsr, {12'h008, mLfsr, 4'h0}, mLfsr[3], mLfsr[7], n % 17 == 5);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule